// File: doc/BRIEF.md
# Section-Granular Address Translation Unit

This block maps 32-bit virtual addresses onto physical addresses for a processor whose memory map is described in coarse 1 MB regions. The map lives in memory as a flat table of 4096 four-byte descriptors, one per megabyte of virtual space, that starts at a 16 KB aligned base. A descriptor either maps its megabyte to a physical megabyte, or it belongs to a 16 MB group of sixteen identical descriptors that map one 16 MB physical region. It can also mark the region as inaccessible. Each mapping carries a cacheable and a bufferable attribute. These attributes decide how the cache and the write buffer treat the access.

Recent translations are kept in a small fully associative buffer. A hit answers without touching memory. A miss reads exactly one descriptor over a simple read port, decodes it, answers the request and, unless the descriptor is a fault, caches the result. A 16 MB mapping takes a single buffer slot that serves all sixteen megabytes. While translation is switched off, every address passes through unchanged and is reported non-cacheable. A flush strobe empties the buffer, for use after software rewrites the table.

Top module: `sect_mmu`

## Requirements
- R1: While `xl_en` is low, an accepted request returns `rsp_pa` equal to `req_va`, with `rsp_cache`, `rsp_buf` and `rsp_fault` low, one cycle after acceptance. No memory read is issued, even when matching buffer entries exist.
- R2: On a miss with `xl_en` high, `mem_rd_valid` rises one cycle after acceptance with `mem_rd_addr` = {`xl_base`, `req_va[31:20]`, 2'b00}. Both stay unchanged until the cycle in which `mem_rd_ack` is high.
- R3: A descriptor with bits [1:0] = 2'b10 and bit 18 = 0 maps one megabyte. The response, one cycle after the ack, has `rsp_pa` = {desc[31:20], va[19:0]}, `rsp_cache` = desc[3], `rsp_buf` = desc[2] and `rsp_fault` low.
- R4: A descriptor with bits [1:0] = 2'b10 and bit 18 = 1 maps 16 MB: `rsp_pa` = {desc[31:24], va[23:0]}, with the attributes taken from bits 3 and 2 as in R3.
- R5: A descriptor whose bits [1:0] are not 2'b10 gives `rsp_fault` high, `rsp_pa` zero and both attributes low. It installs nothing, so the next access to that megabyte walks again.
- R6: A request that hits the buffer is answered one cycle after acceptance without a memory read. Hits can be accepted in consecutive cycles.
- R7: A 16 MB entry serves every megabyte of its 16 MB aligned region without a further walk.
- R8: The buffer holds 8 entries and replaces them in round-robin order. After eight installs following a flush, a ninth install evicts the oldest entry and keeps the others.
- R9: A one-cycle `tlb_flush` pulse invalidates every entry, so the next access to any address walks.
- R10: `req_ready` is low from acceptance of a miss until its response. Every accepted request gets exactly one single-cycle `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xl_en | input | 1 | Translation enable; low means flat mapping |
| xl_base | input | 18 | Table base address bits 31:14 |
| tlb_flush | input | 1 | Invalidate all buffer entries |
| req_valid | input | 1 | Translation request |
| req_va | input | 32 | Virtual address |
| req_ready | output | 1 | Unit can accept a request |
| rsp_valid | output | 1 | Response pulse |
| rsp_pa | output | 32 | Physical address |
| rsp_cache | output | 1 | Region is cacheable |
| rsp_buf | output | 1 | Region is bufferable |
| rsp_fault | output | 1 | Translation fault |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_addr | output | 32 | Descriptor address |
| mem_rd_data | input | 32 | Descriptor read data, valid with ack |
| mem_rd_ack | input | 1 | Read completion |

## Verification
Flat and hit responses are registered at the edge that accepts the request, so the bench samples them at the falling edge right after that edge. It also confirms there that no read was raised and that the pulse is gone one cycle later. For a miss, the read request is checked at that same falling edge and again a cycle later while the ack is withheld. The walk response is sampled at the falling edge after the edge that carries the ack. Eviction and flush are observed only as whether the next access raises a read at its acceptance-plus-one sample point.

// File: rtl/sxl_pkg.sv
// Package: shared widths, descriptor field positions and record types
// for the section-granular translation unit.
// Assumes a 32-bit virtual space cut into 1 MB sections.
package sxl_pkg;

    localparam int VA_W      = 32;
    localparam int SECT_LSB  = 20;                 // 1 MB section
    localparam int SUPER_LSB = 24;                 // 16 MB group
    localparam int TAG_W     = VA_W - SECT_LSB;    // section index width
    localparam int GRP_W     = SUPER_LSB - SECT_LSB;
    localparam int TBL_ALIGN = TAG_W + 2;          // table spans 2^14 bytes
    localparam int BASE_W    = VA_W - TBL_ALIGN;

    // Descriptor field positions
    localparam int D_BUF = 2;
    localparam int D_CAC = 3;
    localparam int D_SUP = 18;
    localparam logic [1:0] D_KIND_SECT = 2'b10;

    // One cached translation
    typedef struct packed {
        logic             vld;
        logic             sup;
        logic [TAG_W-1:0] tag;
        logic [TAG_W-1:0] pab;
        logic             cac;
        logic             buf_;
    } tlb_ent_t;

    // Decoded descriptor
    typedef struct packed {
        logic             fault;
        logic             sup;
        logic [TAG_W-1:0] pab;
        logic             cac;
        logic             buf_;
    } walk_res_t;

    // Form a physical address from a stored base and the virtual offset
    function automatic logic [VA_W-1:0] join_pa(input logic sup,
                                                input logic [TAG_W-1:0] pab,
                                                input logic [VA_W-1:0] va);
        if (sup)
            return {pab[TAG_W-1:GRP_W], va[SUPER_LSB-1:0]};
        else
            return {pab, va[SECT_LSB-1:0]};
    endfunction

    // Tag under which a translation is stored (low group bits cleared for 16 MB)
    function automatic logic [TAG_W-1:0] mk_tag(input logic sup,
                                               input logic [TAG_W-1:0] idx);
        if (sup)
            return {idx[TAG_W-1:GRP_W], {GRP_W{1'b0}}};
        else
            return idx;
    endfunction

endpackage

// File: rtl/sxl_desc_dec.sv
// Descriptor decoder: turns one raw table word into a translation record.
// Assumes only the section kind is legal; every other kind is a fault.
// Purely combinational.
module sxl_desc_dec
    import sxl_pkg::*;
(
    input  logic [31:0] desc,
    output walk_res_t   res
);

    logic is_sect;
    logic unused_desc;

    assign is_sect     = (desc[1:0] == D_KIND_SECT);
    assign unused_desc = ^{desc[D_SUP-1:D_CAC+1], desc[SECT_LSB-1:D_SUP+1]};

    // Decode kind, base and attributes; a fault clears everything else
    always_comb begin
        res = '0;
        if (!is_sect) begin
            res.fault = 1'b1;
        end else begin
            res.sup  = desc[D_SUP];
            res.pab  = mk_tag(desc[D_SUP], desc[31:SECT_LSB]);
            res.cac  = desc[D_CAC];
            res.buf_ = desc[D_BUF];
        end
    end

endmodule

// File: rtl/sxl_tlb.sv
// Fully associative translation buffer with round-robin replacement.
// Lookup is combinational on the section index. Install and flush take
// effect at the clock edge, and flush wins over a same-cycle install.
// Assumes no two valid entries cover the same megabyte; if they did, the
// lowest index would win.
module sxl_tlb
    import sxl_pkg::*;
#(
    parameter int DEPTH = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [TAG_W-1:0] lk_idx,
    output logic             hit,
    output tlb_ent_t         hit_ent,
    input  logic             ins_en,
    input  logic [TAG_W-1:0] ins_idx,
    input  walk_res_t        ins_res
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    tlb_ent_t         ent [DEPTH];
    logic [DEPTH-1:0] match;
    logic [IDX_W-1:0] victim;

    // Per-entry compare: 16 MB entries ignore the low group bits
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = ent[g].vld &&
            (ent[g].sup ? (ent[g].tag[TAG_W-1:GRP_W] == lk_idx[TAG_W-1:GRP_W])
                        : (ent[g].tag == lk_idx));
    end

    // Select the matching entry, lowest index first
    always_comb begin
        hit     = 1'b0;
        hit_ent = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_ent = ent[i];
            end
        end
    end

    // Entry storage: flush clears all, install writes the victim slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                ent[g] <= '0;
            end else if (ins_en && (victim == IDX_W'(g))) begin
                ent[g].vld  <= 1'b1;
                ent[g].sup  <= ins_res.sup;
                ent[g].tag  <= mk_tag(ins_res.sup, ins_idx);
                ent[g].pab  <= ins_res.pab;
                ent[g].cac  <= ins_res.cac;
                ent[g].buf_ <= ins_res.buf_;
            end
        end
    end

    // Round-robin victim pointer, restarted by flush
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            victim <= '0;
        else if (ins_en)
            victim <= (victim == LAST) ? '0 : victim + 1'b1;
    end

endmodule

// File: rtl/sxl_walker.sv
// Single-read table walker. On start it latches the virtual address and
// the descriptor address, raises a read, and holds it until ack. The ack
// cycle yields the decoded descriptor and a done pulse.
// Assumes xl_base does not change during a walk.
module sxl_walker
    import sxl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VA_W-1:0]   start_va,
    input  logic [BASE_W-1:0] base,
    output logic              busy,
    output logic              done,
    output logic [VA_W-1:0]   walk_va,
    output walk_res_t         res,
    output logic              mem_rd_valid,
    output logic [31:0]       mem_rd_addr,
    input  logic [31:0]       mem_rd_data,
    input  logic              mem_rd_ack
);

    typedef enum logic {W_IDLE, W_READ} wstate_t;
    wstate_t st;

    assign busy         = (st == W_READ);
    assign mem_rd_valid = busy;
    assign done         = busy && mem_rd_ack;

    // Walk state: leave idle on start, return on ack
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= W_IDLE;
        else if (st == W_IDLE && start)
            st <= W_READ;
        else if (done)
            st <= W_IDLE;
    end

    // Capture request address and descriptor address at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_va     <= '0;
            mem_rd_addr <= '0;
        end else if (st == W_IDLE && start) begin
            walk_va     <= start_va;
            mem_rd_addr <= {base, start_va[VA_W-1:SECT_LSB], 2'b00};
        end
    end

    sxl_desc_dec u_dec (
        .desc (mem_rd_data),
        .res  (res)
    );

endmodule

// File: rtl/sect_mmu.sv
// Top of the section-granular translation unit. Accepts one request per
// cycle while idle. Flat and hit responses are registered at acceptance;
// misses go through the walker and answer the cycle after the read ack.
// Assumes the caller keeps xl_base stable while a walk is in progress.
module sect_mmu
    import sxl_pkg::*;
#(
    parameter int TLB_DEPTH = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xl_en,
    input  logic [BASE_W-1:0] xl_base,
    input  logic              tlb_flush,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [VA_W-1:0]   rsp_pa,
    output logic              rsp_cache,
    output logic              rsp_buf,
    output logic              rsp_fault,
    output logic              mem_rd_valid,
    output logic [31:0]       mem_rd_addr,
    input  logic [31:0]       mem_rd_data,
    input  logic              mem_rd_ack
);

    logic            accept, walk_busy, walk_done, tlb_hit, walk_start;
    tlb_ent_t        hit_ent;
    walk_res_t       walk_res;
    logic [VA_W-1:0] walk_va;

    assign req_ready  = !walk_busy;
    assign accept     = req_valid && req_ready;
    assign walk_start = accept && xl_en && !tlb_hit;

    sxl_tlb #(.DEPTH(TLB_DEPTH)) u_tlb (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (tlb_flush),
        .lk_idx  (req_va[VA_W-1:SECT_LSB]),
        .hit     (tlb_hit),
        .hit_ent (hit_ent),
        .ins_en  (walk_done && !walk_res.fault),
        .ins_idx (walk_va[VA_W-1:SECT_LSB]),
        .ins_res (walk_res)
    );

    sxl_walker u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (walk_start),
        .start_va     (req_va),
        .base         (xl_base),
        .busy         (walk_busy),
        .done         (walk_done),
        .walk_va      (walk_va),
        .res          (walk_res),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_data  (mem_rd_data),
        .mem_rd_ack   (mem_rd_ack)
    );

    // Response register: flat, hit, or walk result, one pulse per request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_pa    <= '0;
            rsp_cache <= 1'b0;
            rsp_buf   <= 1'b0;
            rsp_fault <= 1'b0;
        end else if (accept && !xl_en) begin
            rsp_valid <= 1'b1;
            rsp_pa    <= req_va;
            rsp_cache <= 1'b0;
            rsp_buf   <= 1'b0;
            rsp_fault <= 1'b0;
        end else if (accept && tlb_hit) begin
            rsp_valid <= 1'b1;
            rsp_pa    <= join_pa(hit_ent.sup, hit_ent.pab, req_va);
            rsp_cache <= hit_ent.cac;
            rsp_buf   <= hit_ent.buf_;
            rsp_fault <= 1'b0;
        end else if (walk_done) begin
            rsp_valid <= 1'b1;
            rsp_pa    <= walk_res.fault ? '0 : join_pa(walk_res.sup, walk_res.pab, walk_va);
            rsp_cache <= walk_res.cac;
            rsp_buf   <= walk_res.buf_;
            rsp_fault <= walk_res.fault;
        end else begin
            rsp_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/sxl_chk.sv
// Checker for sect_mmu: protocol and response properties on its ports.
// Attached to every sect_mmu instance by the bind at the end of this file.
module sxl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        xl_en,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_va,
    input logic        rsp_valid,
    input logic [31:0] rsp_pa,
    input logic        rsp_cache,
    input logic        rsp_buf,
    input logic        rsp_fault,
    input logic        mem_rd_valid,
    input logic [31:0] mem_rd_addr,
    input logic [31:0] mem_rd_data,
    input logic        mem_rd_ack
);

    // R1: flat mode passes the address through with no attributes
    p_flat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xl_en) |=>
            (rsp_valid && rsp_pa == $past(req_va) && !rsp_cache && !rsp_buf && !rsp_fault));

    // R1: flat mode never starts a read
    p_flat_noread_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xl_en) |=> !mem_rd_valid);

    // R2: a pending read holds its address until ack
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ack) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R2: descriptor addresses are word aligned
    p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (mem_rd_addr[1:0] == 2'b00));

    // R3: section attributes follow the descriptor bits
    p_sect_attr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && mem_rd_ack && mem_rd_data[1:0] == 2'b10) |=>
            (rsp_valid && !rsp_fault && rsp_cache == $past(mem_rd_data[3]) &&
             rsp_buf == $past(mem_rd_data[2])));

    // R5: faults carry no attributes and a zero address
    p_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (!rsp_cache && !rsp_buf && rsp_pa == 32'h0));

    // R10: no request accepted while a read is outstanding
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready);

    // R10: the ack of a walk produces a response next cycle
    p_ack_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && mem_rd_ack) |=> rsp_valid);

endmodule

bind sect_mmu sxl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .xl_en        (xl_en),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_va       (req_va),
    .rsp_valid    (rsp_valid),
    .rsp_pa       (rsp_pa),
    .rsp_cache    (rsp_cache),
    .rsp_buf      (rsp_buf),
    .rsp_fault    (rsp_fault),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_data  (mem_rd_data),
    .mem_rd_ack   (mem_rd_ack)
);

// File: tb/sim_sect_mmu.sv
`timescale 1ns/1ps
// Directed bench for sect_mmu: one task per scenario, each checking itself.
module sim_sect_mmu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xl_en = 1'b0;
    logic [17:0] xl_base = 18'h00048;
    logic        tlb_flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        req_ready, rsp_valid, rsp_cache, rsp_buf, rsp_fault;
    logic [31:0] rsp_pa;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        mem_rd_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sect_mmu u0 (
        .clk(clk), .rst_n(rst_n), .xl_en(xl_en), .xl_base(xl_base),
        .tlb_flush(tlb_flush), .req_valid(req_valid), .req_va(req_va),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_cache(rsp_cache), .rsp_buf(rsp_buf), .rsp_fault(rsp_fault),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .mem_rd_ack(mem_rd_ack)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // One request; walk selects the miss path with a delayed ack
    task automatic xlate(input logic [31:0] va, input bit walk, input logic [31:0] desc,
                         input logic [31:0] e_pa, input bit e_c, input bit e_b,
                         input bit e_f, input string rq);
        @(negedge clk);
        req_valid = 1'b1;
        req_va    = va;
        @(negedge clk);
        req_valid = 1'b0;
        if (!walk) begin
            chk(mem_rd_valid, 0, {rq, " no read"});
        end else begin
            chk(rsp_valid, 0, {rq, " no early rsp"});
            chk(mem_rd_valid, 1, "R2 read raised");
            chk(mem_rd_addr, {xl_base, va[31:20], 2'b00}, "R2 read addr");
            chk(req_ready, 0, "R10 busy during walk");
            @(negedge clk);
            chk(mem_rd_valid, 1, "R2 read held");
            mem_rd_ack  = 1'b1;
            mem_rd_data = desc;
            @(negedge clk);
            mem_rd_ack  = 1'b0;
            mem_rd_data = '0;
        end
        chk(rsp_valid, 1, {rq, " rsp_valid"});
        chk(rsp_pa, e_pa, {rq, " pa"});
        chk({rsp_cache, rsp_buf, rsp_fault}, {e_c, e_b, e_f}, {rq, " c/b/fault"});
        @(negedge clk);
        chk(rsp_valid, 0, "R10 single pulse");
    endtask

    task automatic t_reset();
        chk({rsp_valid, mem_rd_valid, req_ready}, 3'b001, "reset state");
    endtask

    task automatic t_flush();
        @(negedge clk);
        tlb_flush = 1'b1;
        @(negedge clk);
        tlb_flush = 1'b0;
    endtask

    // R6: two hits accepted in consecutive cycles
    task automatic t_back2back();
        @(negedge clk);
        req_valid = 1'b1;
        req_va    = 32'h0040_0010;
        @(negedge clk);
        chk(rsp_valid, 1, "R6 b2b first valid");
        chk(rsp_pa, 32'h8000_0010, "R6 b2b first pa");
        req_va = 32'h05A0_0000;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid, 1, "R6 b2b second valid");
        chk(rsp_pa, 32'h9AA0_0000, "R7 b2b second pa");
        chk(mem_rd_valid, 0, "R6 b2b no read");
    endtask

    // R8: fill eight slots, ninth evicts the oldest
    task automatic t_evict();
        xlate(32'h0040_1234, 1, 32'h8000_000E, 32'h8000_1234, 1, 1, 0, "R9 walk after flush");
        for (int i = 1; i < 8; i++) begin
            xlate(32'h0100_0000 | (i << 20), 1, 32'h4000_0006 | (i << 20),
                  32'h4000_0000 | (i << 20), 0, 1, 0, "R8 fill");
        end
        xlate(32'h0200_0000, 1, 32'h4800_000A, 32'h4800_0000, 1, 0, 0, "R8 ninth");
        xlate(32'h0110_0000, 0, '0, 32'h4010_0000, 0, 1, 0, "R8 survivor hit");
        xlate(32'h0040_1234, 1, 32'h8000_000E, 32'h8000_1234, 1, 1, 0, "R8 oldest evicted");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        // R1 flat
        xlate(32'h1234_5678, 0, '0, 32'h1234_5678, 0, 0, 0, "R1 flat");
        xl_en = 1'b1;
        // R3 cacheable section, then R6 hit in same MB
        xlate(32'h0040_1234, 1, 32'h8000_000E, 32'h8000_1234, 1, 1, 0, "R3 ram section");
        xlate(32'h004F_FFFC, 0, '0, 32'h800F_FFFC, 1, 1, 0, "R6 hit");
        // R3 device section
        xlate(32'h2010_0000, 1, 32'h3F20_0002, 32'h3F20_0000, 0, 0, 0, "R3 device section");
        // R4 16 MB mapping, R7 other megabyte of it hits
        xlate(32'h0530_0040, 1, 32'h9A04_000E, 32'h9A30_0040, 1, 1, 0, "R4 super walk");
        xlate(32'h05F0_0008, 0, '0, 32'h9AF0_0008, 1, 1, 0, "R7 super hit");
        t_back2back();
        // R5 fault descriptors, no install
        xlate(32'h7000_0000, 1, 32'h0000_000C, 32'h0, 0, 0, 1, "R5 fault kind 00");
        xlate(32'h7000_0000, 1, 32'h0000_0001, 32'h0, 0, 0, 1, "R5 fault rewalk");
        // R1 flat ignores buffer contents
        xl_en = 1'b0;
        xlate(32'h0040_1234, 0, '0, 32'h0040_1234, 0, 0, 0, "R1 flat with entries");
        xl_en = 1'b1;
        // R9 flush then R8 replacement order
        t_flush();
        t_evict();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule